// File: doc/BRIEF.md
# First-Order Wave Digital Allpass Section

This block is a first-order allpass filter built as a wave digital structure. It uses one symmetric two-port adaptor. The input sample drives one adaptor port. The other port is closed through a single delay register. The reflected wave at the input side is the filtered output. Its transfer function from input to output is (−γ + z⁻¹)/(1 − γ·z⁻¹), where γ is the adaptor's reflection coefficient with −1 < γ < 1. Several such sections are cascaded to build the two allpass branches of a lattice filter.

The reflection coefficient is never multiplied directly. A compile-time parameter selects one of four adaptor variants by the sign and size of γ. Each variant multiplies only by a constant α in 0 ≤ α ≤ 1/2. It then forms γ times the difference wave with at most one extra add or subtract:

| Variant | γ range | α | γ in terms of α |
|---|---|---|---|
| 1 | 1/2 < γ < 1 | 1 − γ | 1 − α |
| 2 | 0 < γ ≤ 1/2 | γ | α |
| 3 | −1/2 ≤ γ < 0 | −γ | −α |
| 4 | −1 < γ < −1/2 | 1 + γ | α − 1 |

The constant α is given as a canonic signed digit pattern: one mask of positive digits and one mask of negative digits. The product is therefore a chain of shifted adds and subtracts, one adder for each nonzero digit after the first.

Samples arrive with a valid strobe. The delay register moves only on strobed samples. The output is registered and carries its own valid flag. The internal state keeps two guard bits, and both the state and the output saturate instead of wrapping.

Top module: `wdf1_allpass`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_sample` and the delay state are all zero. The first sample after reset is processed with a zero state.
- R2: A sample presented with `in_valid` high at a rising clock edge produces its result on `out_sample` with `out_valid` high, both updated at that same edge. `out_valid` is low after any edge where `in_valid` was low.
- R3: At an edge where `in_valid` is low, `out_sample` and the delay state keep their values. A later sample therefore gives the same result whether or not idle cycles came before it.
- R4: Let A = ALPHA_POS − ALPHA_NEG, read as unsigned integers, where bit i of each mask weighs 2^i/2^FRAC_W. Let d = s − x, where s is the delay state and x is the input. The scaled term is p = floor(d·A / 2^FRAC_W), and it is exact for any 0 ≤ A ≤ 2^(FRAC_W−1).
- R5: Variant 1 (ADP_T1) forms the reflected difference g = d − p.
- R6: Variant 2 (ADP_T2) forms g = p.
- R7: Variant 3 (ADP_T3) forms g = −p.
- R8: Variant 4 (ADP_T4) forms g = p − d.
- R9: On a strobed sample the delay state becomes g + x, saturated to the signed range of DATA_W+GUARD_W bits (−512..511 by default).
- R10: On a strobed sample the output becomes g + s, saturated to the signed DATA_W-bit range (−128..127 by default).
- R11: In all four variants the response to an impulse from the zero state follows (−γ + z⁻¹)/(1 − γ·z⁻¹) with the variant's γ, apart from the floor rounding of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously by an upstream reset synchronizer. |
| in_valid | input | 1 | Sample strobe; the block advances one sample per high cycle |
| in_sample | input | DATA_W | Signed two's complement input sample |
| out_valid | output | 1 | High for one cycle after each accepted sample |
| out_sample | output | DATA_W | Signed, saturated allpass output |

## Verification
The section has one register stage, so each accepted sample's result is due at the same rising edge that accepts it. The bench drives inputs 1 ns after a rising edge. Its behavioural integer model updates on the next rising edge. Both the model and the four design instances are then compared at the falling edge that follows, when the result must be visible. After each idle cycle the same falling-edge comparison checks that nothing moved. Another sample, one edge later, shows that the hidden state was kept.

// File: rtl/wdf1_pkg.sv
`timescale 1ns/1ps
package wdf1_pkg;

  // Adaptor variant, chosen from the range of the reflection coefficient.
  typedef enum logic [1:0] {
    ADP_T1 = 2'd0,  // 1/2 < gamma < 1,   gamma = 1 - alpha
    ADP_T2 = 2'd1,  // 0 < gamma <= 1/2,  gamma = alpha
    ADP_T3 = 2'd2,  // -1/2 <= gamma < 0, gamma = -alpha
    ADP_T4 = 2'd3   // -1 < gamma < -1/2, gamma = alpha - 1
  } adaptor_e;

  // Integer numerator of alpha over 2^frac from the two digit masks.
  function automatic int alpha_num(input logic [31:0] pos, input logic [31:0] neg);
    return int'(pos) - int'(neg);
  endfunction

endpackage

// File: rtl/wdf1_csd_scale.sv
`timescale 1ns/1ps
// Constant multiply of the difference wave by alpha, built as a chain of
// shifted adds/subtracts, one stage per nonzero signed digit.
// The chain runs with FRAC_W extra low bits so every shift is exact; the
// result is floored once at the end.
module wdf1_csd_scale #(
  parameter int unsigned DIFF_W = 11,
  parameter int unsigned FRAC_W = 8,
  parameter logic [FRAC_W:0] POS = '0,
  parameter logic [FRAC_W:0] NEG = '0
) (
  input  logic signed [DIFF_W-1:0] diff,
  output logic signed [DIFF_W+1:0] prod
);

  localparam int unsigned ACC_W = DIFF_W + FRAC_W + 2;
  localparam int unsigned STAGES = FRAC_W + 1;

  logic signed [ACC_W-1:0] diff_x;
  logic signed [ACC_W-1:0] acc [0:STAGES];
  logic [FRAC_W-1:0] unused_frac;

  assign diff_x = ACC_W'(diff);
  assign acc[0] = '0;

  for (genvar i = 0; i < STAGES; i++) begin : g_digit
    if (POS[i]) begin : g_add
      assign acc[i+1] = acc[i] + (diff_x <<< i);
    end else if (NEG[i]) begin : g_sub
      assign acc[i+1] = acc[i] - (diff_x <<< i);
    end else begin : g_pass
      assign acc[i+1] = acc[i];
    end
  end

  // Dropping the low FRAC_W bits of a two's complement value is a floor.
  assign prod        = $signed(acc[STAGES][ACC_W-1:FRAC_W]);
  assign unused_frac = acc[STAGES][FRAC_W-1:0];

endmodule

// File: rtl/wdf1_gamma_map.sv
`timescale 1ns/1ps
// Turns the alpha-scaled difference into the gamma-scaled difference
// according to the adaptor variant.
module wdf1_gamma_map
  import wdf1_pkg::*;
#(
  parameter int unsigned DIFF_W = 11,
  parameter adaptor_e    ADAPTOR = ADP_T2
) (
  input  logic signed [DIFF_W-1:0] diff,
  input  logic signed [DIFF_W+1:0] prod,
  output logic signed [DIFF_W+1:0] refl
);

  localparam int unsigned G_W = DIFF_W + 2;

  logic signed [G_W-1:0] diff_x;
  assign diff_x = G_W'(diff);

  if (ADAPTOR == ADP_T1) begin : g_t1
    assign refl = diff_x - prod;
  end else if (ADAPTOR == ADP_T2) begin : g_t2
    assign refl = prod;
  end else if (ADAPTOR == ADP_T3) begin : g_t3
    assign refl = -prod;
  end else begin : g_t4
    assign refl = prod - diff_x;
  end

endmodule

// File: rtl/wdf1_sat.sv
`timescale 1ns/1ps
// Signed saturation from IN_W bits down to OUT_W bits.
module wdf1_sat #(
  parameter int unsigned IN_W  = 14,
  parameter int unsigned OUT_W = 8
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);

  localparam logic signed [OUT_W-1:0] OUT_HI = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OUT_LO = {1'b1, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (din > IN_W'(OUT_HI)) begin
      dout = OUT_HI;
    end else if (din < IN_W'(OUT_LO)) begin
      dout = OUT_LO;
    end else begin
      dout = din[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/wdf1_allpass.sv
`timescale 1ns/1ps
// First-order wave digital allpass section: one symmetric two-port adaptor
// with its second port closed through a unit delay.
//   a1 = input, a2 = delay state, b1 = output, b2 = next state
//   g  = gamma * (a2 - a1);  b1 = g + a2;  b2 = g + a1
module wdf1_allpass
  import wdf1_pkg::*;
#(
  parameter int unsigned      DATA_W    = 8,
  parameter int unsigned      GUARD_W   = 2,
  parameter int unsigned      FRAC_W    = 8,
  parameter adaptor_e         ADAPTOR   = ADP_T2,
  parameter logic [FRAC_W:0]  ALPHA_POS = 9'b001010100,
  parameter logic [FRAC_W:0]  ALPHA_NEG = 9'b000000000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);

  localparam int unsigned ST_W  = DATA_W + GUARD_W;  // delay state width
  localparam int unsigned DF_W  = ST_W + 1;          // difference wave
  localparam int unsigned G_W   = DF_W + 2;          // scaled waves
  localparam int unsigned SUM_W = G_W + 1;           // adaptor outputs

  // ---------------------------------------------------------------- state
  logic signed [ST_W-1:0]   state_q;
  logic signed [DATA_W-1:0] out_q;
  logic                     vld_q;

  // ------------------------------------------------------------ datapath
  logic signed [DF_W-1:0]   diff;
  logic signed [G_W-1:0]    prod;
  logic signed [G_W-1:0]    refl;
  logic signed [SUM_W-1:0]  sum_b1;
  logic signed [SUM_W-1:0]  sum_b2;
  logic signed [ST_W-1:0]   b2_sat;
  logic signed [DATA_W-1:0] b1_sat;

  assign diff = DF_W'(state_q) - DF_W'(in_sample);

  wdf1_csd_scale #(
    .DIFF_W (DF_W),
    .FRAC_W (FRAC_W),
    .POS    (ALPHA_POS),
    .NEG    (ALPHA_NEG)
  ) u_scale (
    .diff (diff),
    .prod (prod)
  );

  wdf1_gamma_map #(
    .DIFF_W  (DF_W),
    .ADAPTOR (ADAPTOR)
  ) u_gmap (
    .diff (diff),
    .prod (prod),
    .refl (refl)
  );

  assign sum_b1 = SUM_W'(refl) + SUM_W'(state_q);
  assign sum_b2 = SUM_W'(refl) + SUM_W'(in_sample);

  wdf1_sat #(.IN_W(SUM_W), .OUT_W(DATA_W)) u_sat_out (
    .din  (sum_b1),
    .dout (b1_sat)
  );

  wdf1_sat #(.IN_W(SUM_W), .OUT_W(ST_W)) u_sat_state (
    .din  (sum_b2),
    .dout (b2_sat)
  );

  // ---------------------------------------------------------- next state
  logic                     adv;
  logic signed [ST_W-1:0]   state_d;
  logic signed [DATA_W-1:0] out_d;
  logic                     vld_d;

  always_comb begin
    adv     = in_valid;
    state_d = b2_sat;
    out_d   = b1_sat;
    vld_d   = in_valid;
  end

  // ------------------------------------------------------------ registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      out_q   <= '0;
    end else if (adv) begin
      state_q <= state_d;
      out_q   <= out_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_sample = out_q;

endmodule

// File: rtl/wdf1_allpass_chk.sv
`timescale 1ns/1ps
module wdf1_allpass_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ST_W   = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_sample,
  input logic signed [ST_W-1:0]   state
);

  // R1: a held reset keeps every register cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_sample == '0 && state == '0))
    else $error("R1 violated: registers not clear in reset");

  // R2: an accepted sample yields a valid output after that edge
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid)
    else $error("R2 violated: missing out_valid");

  // R2: no output strobe without a sample
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid)
    else $error("R2 violated: spurious out_valid");

  // R3: idle cycles keep the output
  p_hold_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample))
    else $error("R3 violated: output moved while idle");

  // R3: idle cycles keep the delay state
  p_hold_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(state))
    else $error("R3 violated: state moved while idle");

endmodule

bind wdf1_allpass wdf1_allpass_chk #(
  .DATA_W (DATA_W),
  .ST_W   (ST_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_sample (out_sample),
  .state      (state_q)
);

// File: tb/tb_wdf1_allpass.sv
`timescale 1ns/1ps
module tb_wdf1_allpass;
  import wdf1_pkg::*;

  localparam int W = 8;
  localparam int F = 8;
  localparam int NT = 4;
  localparam int ST_HI = 511, ST_LO = -512;
  localparam int Y_HI = 127, Y_LO = -128;

  // alpha per variant (mask bit i weighs 2^i/256)
  localparam logic [F:0] POS_T [NT] = '{9'b001010101, 9'b001010100, 9'b010000000, 9'b010000010};
  localparam logic [F:0] NEG_T [NT] = '{9'b000000000, 9'b000000000, 9'b000000001, 9'b000100000};

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_sample = '0;
  logic                out_valid [NT];
  logic signed [W-1:0] out_sample [NT];

  always #2.5 clk = ~clk;

  for (genvar k = 0; k < NT; k++) begin : g_inst
    wdf1_allpass #(
      .DATA_W(W), .GUARD_W(2), .FRAC_W(F),
      .ADAPTOR(adaptor_e'(k)),
      .ALPHA_POS(POS_T[k]), .ALPHA_NEG(NEG_T[k])
    ) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(out_valid[k]), .out_sample(out_sample[k])
    );
  end

  // ------------------------------------------------------ reference model
  int m_state [NT];
  int m_out   [NT];
  bit m_vld;

  function automatic int sat(input int v, input int lo, input int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NT; k++) begin
        m_state[k] <= 0;
        m_out[k]   <= 0;
      end
      m_vld <= 1'b0;
    end else begin
      m_vld <= in_valid;
      if (in_valid) begin
        for (int k = 0; k < NT; k++) begin
          int s, x, d, a, p, g;
          s = m_state[k];
          x = int'(in_sample);
          d = s - x;
          a = alpha_num(32'(POS_T[k]), 32'(NEG_T[k]));
          p = (d * a) >>> F;               // floor division by 256 (R4)
          case (k)
            0: g = d - p;                  // R5
            1: g = p;                      // R6
            2: g = -p;                     // R7
            default: g = p - d;            // R8
          endcase
          m_state[k] <= sat(g + x, ST_LO, ST_HI);  // R9
          m_out[k]   <= sat(g + s, Y_LO, Y_HI);    // R10
        end
      end
    end
  end

  // ---------------------------------------------------------- comparison
  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";
  string ttag [NT] = '{"R5", "R6", "R7", "R8"};

  always @(negedge clk) begin
    for (int k = 0; k < NT; k++) begin
      n_cmp++;
      if (out_valid[k] !== m_vld) begin
        n_bad++;
        $display("FAIL R2 (%s) variant %0d out_valid: actual %0b expected %0b",
                 phase, k + 1, out_valid[k], m_vld);
      end
      n_cmp++;
      if (int'(out_sample[k]) != m_out[k]) begin
        n_bad++;
        $display("FAIL %s/%s variant %0d out_sample at %0t: actual %0d expected %0d",
                 phase, ttag[k], k + 1, $time, out_sample[k], m_out[k]);
      end
    end
  end

  // ------------------------------------------------------------ stimulus
  task automatic drive(input bit v, input int x);
    @(posedge clk);
    #1;
    in_valid  = v;
    in_sample = W'(x);
  endtask

  bit done = 1'b0;

  initial begin
    #1 rst_n = 1'b0;
    phase = "R1";
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // impulse from zero state, one per amplitude sign
    phase = "R11";
    drive(1, 100);
    for (int i = 0; i < 14; i++) drive(1, 0);
    drive(1, -90);
    for (int i = 0; i < 14; i++) drive(1, 0);

    // dense random samples
    phase = "R4";
    for (int i = 0; i < 400; i++) drive(1, int'($urandom_range(0, 255)) - 128);

    // random samples with idle gaps
    phase = "R3";
    for (int i = 0; i < 400; i++) begin
      bit v;
      v = ($urandom_range(0, 9) < 6);
      drive(v, int'($urandom_range(0, 255)) - 128);
    end

    // full-scale patterns driving the guard bits and output into saturation
    phase = "R9/R10";
    for (int i = 0; i < 60; i++) drive(1, (i % 2 == 0) ? 127 : -128);
    for (int i = 0; i < 30; i++) drive(1, -128);
    for (int i = 0; i < 30; i++) drive(1, 127);
    for (int i = 0; i < 60; i++) drive(1, (i % 2 == 0) ? -128 : 127);

    // reset in mid stream, then first sample must see a cleared state
    phase = "R1";
    drive(1, 77);
    @(posedge clk);
    #1 rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    phase = "R11";
    drive(1, 64);
    for (int i = 0; i < 8; i++) drive(1, 0);
    drive(0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule